// File: doc/BRIEF.md
# DMA Bus-Available Grant Handshake

This block sits between an external device that asks for the shared synchronous DRAM bus and the DMA engine that answers. The device raises a one-cycle request strobe. The block records it and, one clock later, raises a bus-available grant. The grant normally lasts a single cycle. If the memory controller reports a row miss to a bank that has not been precharged in the cycle the grant starts, the grant is held for a number of cycles set by a small precharge-interval setting.

Only one request may be outstanding at a time. A strobe that arrives while an earlier one is still waiting for its grant is a protocol violation. It sets a sticky error flag and produces no second grant. A strobe that arrives while a row-miss grant is being held is dropped without any trace. A synchronous reset returns the block to idle.

Top module: `bus_grant_hs`

## Requirements
- R1: A request strobe (`bus_req_i` high for one cycle) sampled at clock edge N, and accepted at that edge, makes `bus_avail_o` high in the cycle that follows edge N+1.
- R2: If `row_miss_i` is low at the edge where the grant starts, `bus_avail_o` stays high for exactly one cycle.
- R3: If `row_miss_i` is high at the edge where the grant starts, `bus_avail_o` stays high for `prech_cfg_i`+1 cycles. `prech_cfg_i` is read at that same edge, so values 0 to 7 give 1 to 8 cycles.
- R4: A request sampled while a grant that began with a row miss is still high (including its last cycle) is discarded. It produces no grant and leaves `proto_err_o` unchanged.
- R5: A request sampled while an earlier accepted request has not yet started its grant sets `proto_err_o`, which then stays high until reset. The second request produces no grant.
- R6: A request sampled while a one-cycle (no row miss) grant is high is accepted normally and gets its own grant.
- R7: While `rst` is high at a clock edge, the pending request, the grant counter and the error flag are cleared, so both outputs are low after that edge.
- R8: `row_miss_i` and `prech_cfg_i` are ignored at every edge except the one where a grant starts. Changing them during a held grant does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_i | input | 1 | Request strobe from the external device, one cycle per request |
| row_miss_i | input | 1 | Memory controller reports a row miss to a bank that is not precharged |
| prech_cfg_i | input | CFG_W | Precharge interval setting n; the hold time is n+1 cycles |
| bus_avail_o | output | 1 | Bus-available grant to the device |
| proto_err_o | output | 1 | Sticky flag: a second request arrived before the first was granted |

## Verification
The embedded assertions check on every cycle the following properties:
- a pending request always turns into a grant at the next edge;
- a grant started without a row miss loads a single cycle;
- a row-miss grant loads the configured hold time;
- no request becomes pending while a row-miss grant is held;
- an overlapping request raises the error flag, which never falls again without reset.

Grant lengths measured end to end, the dropping of requests during a held grant, back-to-back acceptance after a one-cycle grant, and the fact that the row-miss input is ignored during a grant can only be shown by the bench's scenarios. The bench's cycle-by-cycle reference model covers these, along with a long random run.

// File: rtl/bgh_pkg.sv
package bgh_pkg;

  // Grant hold length in cycles: one on a row hit, setting+1 on a row miss.
  function automatic int unsigned hold_len(input logic miss, input int unsigned setting);
    return miss ? setting + 1 : 1;
  endfunction

  // Width needed to count up to 2**cfg_w cycles.
  function automatic int unsigned cnt_width(input int unsigned cfg_w);
    return cfg_w + 1;
  endfunction

endpackage

// File: rtl/bgh_req_track.sv
module bgh_req_track (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic drop_i,
  output logic pend_o,
  output logic accept_o,
  output logic overlap_o,
  output logic err_o
);

  logic pend_q;
  logic err_q;
  logic pend_d;
  logic err_d;

  // A strobe counts only when no row-miss grant is being held.
  assign accept_o  = req_i && !drop_i;
  // A counted strobe while one is already waiting breaks the protocol.
  assign overlap_o = accept_o && pend_q;
  assign pend_d    = accept_o && !pend_q;
  assign err_d     = err_q || overlap_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;

  // R5
  overlap_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    overlap_o |=> err_o);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // R5
  overlap_no_queue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && pend_o) |=> !pend_o);

  // R4
  drop_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && drop_i) |=> !pend_o);

endmodule

// File: rtl/bgh_grant_timer.sv
module bgh_grant_timer #(
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             miss_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             grant_o,
  output logic             long_busy_o
);

  import bgh_pkg::*;

  localparam int unsigned CNT_W = cnt_width(CFG_W);
  localparam int unsigned MAX_H = 1 << CFG_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             long_q;
  logic             long_d;

  assign load_val = CNT_W'(hold_len(miss_i, int'(cfg_i)));

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (load_i) begin
      cnt_d  = load_val;
      long_d = miss_i;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) long_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

  assign grant_o     = (cnt_q != '0);
  assign long_busy_o = long_q && grant_o;

  // R2
  hit_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !miss_i) |=> (cnt_q == CNT_W'(1) && !long_q));

  // R3
  miss_hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && miss_i) |=> (cnt_q == CNT_W'($past(cfg_i)) + CNT_W'(1)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_H));

endmodule

// File: rtl/bus_grant_hs.sv
module bus_grant_hs #(
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req_i,
  input  logic             row_miss_i,
  input  logic [CFG_W-1:0] prech_cfg_i,
  output logic             bus_avail_o,
  output logic             proto_err_o
);

  logic req_pend;
  logic req_accept;
  logic req_overlap;
  logic grant_long;
  logic grant_on;

  bgh_req_track u_track (
    .clk       (clk),
    .rst       (rst),
    .req_i     (bus_req_i),
    .drop_i    (grant_long),
    .pend_o    (req_pend),
    .accept_o  (req_accept),
    .overlap_o (req_overlap),
    .err_o     (proto_err_o)
  );

  bgh_grant_timer #(.CFG_W(CFG_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load_i      (req_pend),
    .miss_i      (row_miss_i),
    .cfg_i       (prech_cfg_i),
    .grant_o     (grant_on),
    .long_busy_o (grant_long)
  );

  assign bus_avail_o = grant_on;

  // R1
  pend_to_grant_chk: assert property (@(posedge clk) disable iff (rst)
    req_pend |=> bus_avail_o);

  // R1
  accept_then_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (req_accept && !req_overlap) |=> req_pend);

  // R4
  no_pend_in_long_chk: assert property (@(posedge clk) disable iff (rst)
    grant_long |-> !req_pend);

endmodule

// File: tb/bus_grant_hs_bench.sv
`timescale 1ns/1ps
module bus_grant_hs_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       miss = 1'b0;
  logic [2:0] cfg = 3'd0;
  logic       avail;
  logic       err;

  int checks = 0;
  int failures = 0;

  // reference model state
  int  m_cnt = 0;
  bit  m_long = 0;
  bit  m_pend = 0;
  bit  m_err = 0;

  always #2.5 clk = ~clk;

  bus_grant_hs #(.CFG_W(3)) u_bus_grant_hs (
    .clk         (clk),
    .rst         (rst),
    .bus_req_i   (req),
    .row_miss_i  (miss),
    .prech_cfg_i (cfg),
    .bus_avail_o (avail),
    .proto_err_o (err)
  );

  // Behavioural model updated on each rising edge from the held inputs.
  always @(posedge clk) begin
    bit held_long;
    bit was_pend;
    if (rst) begin
      m_cnt = 0; m_long = 0; m_pend = 0; m_err = 0;
    end else begin
      held_long = (m_cnt > 0) && m_long;
      was_pend  = m_pend;
      if (was_pend) begin
        m_cnt  = miss ? int'(cfg) + 1 : 1;
        m_long = miss;
      end else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
      m_pend = 0;
      if (req && !held_long) begin
        if (was_pend) m_err = 1;
        else m_pend = 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Set inputs after a falling edge, then compare model and design at the next one.
  task automatic tick(input bit r, input bit m, input logic [2:0] c);
    req = r; miss = m; cfg = c;
    @(negedge clk);
    check("R1 R2 R3 model grant", int'(avail), int'(m_cnt > 0));
    check("R4 R5 model error", int'(err), int'(m_err));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(0, 0, 0);
    tick(0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    int len;
    int grants;
    @(negedge clk);
    do_reset();
    check("R7 reset grant", int'(avail), 0);
    check("R7 reset error", int'(err), 0);

    // R1 / R2: latency and one-cycle grant
    tick(1, 0, 7);
    check("R1 no grant yet", int'(avail), 0);
    tick(0, 0, 7);
    check("R1 grant after one cycle", int'(avail), 1);
    tick(0, 0, 7);
    check("R2 one-cycle grant", int'(avail), 0);
    tick(0, 0, 0);

    // R3 / R8: row miss hold of cfg+1, miss and cfg toggled during the hold
    tick(1, 0, 3'd5);
    tick(0, 1, 3'd5);
    len = 0;
    for (int i = 0; i < 12; i++) begin
      if (avail) len++;
      tick(0, i[0], 3'(i));
    end
    check("R3 R8 miss hold length", len, 6);

    // R3 boundary: setting 0 on a miss gives one cycle
    tick(1, 0, 0);
    tick(0, 1, 0);
    len = 0;
    for (int i = 0; i < 4; i++) begin
      if (avail) len++;
      tick(0, 0, 0);
    end
    check("R3 setting zero length", len, 1);

    // R4: request during held grant, including its final cycle, is dropped
    tick(1, 0, 3'd3);
    tick(0, 1, 3'd3);
    tick(1, 0, 0);
    tick(0, 0, 0);
    tick(0, 0, 0);
    tick(1, 0, 0);
    grants = 4;
    for (int i = 0; i < 6; i++) begin
      if (avail) grants++;
      tick(0, 0, 0);
    end
    check("R4 dropped request gives no grant", grants, 4);
    check("R4 dropped request no error", int'(err), 0);

    // R6: request during a one-cycle grant is accepted
    tick(1, 0, 0);
    tick(0, 0, 0);
    check("R6 first grant", int'(avail), 1);
    tick(1, 0, 0);
    grants = 0;
    for (int i = 0; i < 4; i++) begin
      if (avail) grants++;
      tick(0, 0, 0);
    end
    check("R6 second grant seen", grants, 1);
    check("R6 no error", int'(err), 0);

    // R5: overlapping request
    tick(1, 0, 0);
    tick(1, 0, 0);
    check("R5 error set", int'(err), 1);
    grants = 0;
    for (int i = 0; i < 5; i++) begin
      if (avail) grants++;
      tick(0, 0, 0);
    end
    check("R5 single grant", grants, 1);
    check("R5 error sticky", int'(err), 1);

    // R7: reset clears error and a grant in progress
    tick(1, 0, 3'd7);
    tick(0, 1, 3'd7);
    do_reset();
    check("R7 reset clears grant", int'(avail), 0);
    check("R7 reset clears error", int'(err), 0);

    // random run against the model
    for (int i = 0; i < 2000; i++) begin
      if (i == 1000) do_reset();
      tick(($urandom % 4) == 0, $urandom % 2, 3'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule